// File: doc/BRIEF.md
# On-Screen Effect Timebase

This block derives the slow timing that an on-screen display needs for its visual effects from a one-millisecond tick. It keeps a repeating blink phase whose period and visible fraction are programmable, and it derives from that phase a flag that tells the pixel path to exchange character and background colours. It also runs two one-shot ramps. The first is a line boundary that moves down the text area, so that text is revealed or wiped from the top row to the bottom row. The second is a 4-bit brightness level for fading the display in or out.

Control comes from frame-control style bits held elsewhere: a blink speed bit, a 2-bit duty code, and for the scroll and fade ramps a duration bit, an enable, a direction and a start pulse. The outputs are steady levels that the pixel datapath samples. This block does not mix any pixels.

Top module: `fx_timebase`

## Requirements
- R1: After reset, blink_visible is 1, color_swap is 0, scroll_line is 0, scroll_busy is 0, scroll_erase is 0, and fade_level is 15 while fade_en is low.
- R2: The blink phase counter advances once per tick_ms. One period is 1000 ticks when the long period is selected (blink_fast = 0) and 500 ticks when blink_fast = 1. The first period after reset is always the long period.
- R3: With the counter at position c within a period of P ticks, blink_visible is 1 when c < (P/4)·d, where d is blink_duty read as an unsigned number (1 = a quarter, 2 = a half, 3 = three quarters). With blink_duty = 0, blink_visible stays 1.
- R4: A change of blink_fast takes effect only when the counter wraps at the end of a period. It never shortens or lengthens the period in progress.
- R5: color_swap equals cblink_en AND NOT blink_visible, so it uses the same period and duty as character blink.
- R6: After an accepted scroll start, let k be the number of ticks since the start and D the duration (1000 ticks if scroll_long = 1, 500 otherwise). scroll_line is then floor(k·H/D), where H is scroll_height latched at the start (H ≤ 500). The value holds at H once k = D.
- R7: scroll_busy is 1 from an accepted scroll start until the tick that makes k = D. A start in the same cycle as a tick restarts the ramp at k = 0, and that tick is not counted. A start during a run restarts the ramp.
- R8: scroll_erase shows scroll_dir as latched at the last accepted start (1 = wipe, 0 = reveal). A scroll_start while scroll_en is low is ignored and leaves every scroll output unchanged.
- R9: After an accepted fade start with duration D (1000 ticks if fade_long = 1, otherwise 500), let L = floor(15·k/D). fade_level is L for a fade-in (fade_out_sel = 0) or 15 − L for a fade-out. It holds its end value after k = D.
- R10: While fade_en is low, fade_level is 15 and any fade_start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| blink_fast | input | 1 | 1 selects the 500-tick blink period |
| blink_duty | input | 2 | Visible fraction code: 0 off, 1 quarter, 2 half, 3 three quarters |
| cblink_en | input | 1 | Enables the colour-swap flag |
| scroll_en | input | 1 | Enables acceptance of scroll starts |
| scroll_long | input | 1 | 1 selects the 1000-tick scroll duration |
| scroll_dir | input | 1 | 1 wipe, 0 reveal |
| scroll_start | input | 1 | Starts or restarts the scroll ramp |
| scroll_height | input | LINE_W | Number of lines the ramp covers |
| fade_en | input | 1 | Enables the fade effect |
| fade_long | input | 1 | 1 selects the 1000-tick fade duration |
| fade_out_sel | input | 1 | 1 fade-out, 0 fade-in |
| fade_start | input | 1 | Starts or restarts the fade ramp |
| blink_visible | output | 1 | Blinking characters are shown |
| color_swap | output | 1 | Exchange character and background colours |
| scroll_line | output | LINE_W | Scroll boundary line counted from the top |
| scroll_busy | output | 1 | Scroll ramp is running |
| scroll_erase | output | 1 | Latched scroll direction |
| fade_level | output | 4 | Brightness level, 0 to 15 |

## Verification
A restart and a tick can land in the same clock cycle, and a blink period can wrap in that cycle too. The blink counter must count that tick, while the restarted scroll or fade ramp must begin again from zero and ignore it. The bench issues scroll and fade starts both alone and together with ticks, including one cycle where both ramps restart on a tick while the blink phase runs. It also changes the blink speed partway through a period. Every tick is compared against an independent tick-level model of all six outputs, so any wrong handling of a coincident event shows up as a wrong count on a later tick.

// File: rtl/fx_pkg.sv
package fx_pkg;
    typedef enum logic [1:0] {
        DUTY_OFF  = 2'd0,
        DUTY_Q1   = 2'd1,
        DUTY_HALF = 2'd2,
        DUTY_Q3   = 2'd3
    } duty_e;

    localparam int FADE_TOP = 15;
    localparam int FADE_W   = 4;
endpackage

// File: rtl/fx_blink_phase.sv
module fx_blink_phase #(
    parameter int SHORT_T = 500,
    parameter int LONG_T  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fast_sel,
    input  logic [1:0] duty,
    input  logic       swap_en,
    output logic       vis,
    output logic       swap
);
    import fx_pkg::*;

    localparam int CW = $clog2(LONG_T);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          long_p;
    } blk_st_t;

    blk_st_t       st_d, st_q;
    logic [CW:0]   per;
    logic [CW+2:0] thr;

    always_comb begin
        per  = st_q.long_p ? (CW+1)'(LONG_T) : (CW+1)'(SHORT_T);
        thr  = (CW+3)'(per >> 2) * (CW+3)'(duty);
        st_d = st_q;
        if (tick) begin
            if ({1'b0, st_q.cnt} == per - 1'b1) begin
                st_d.cnt    = '0;
                st_d.long_p = !fast_sel;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        vis  = (duty_e'(duty) == DUTY_OFF) || ((CW+3)'(st_q.cnt) < thr);
        swap = swap_en && !vis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.long_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fx_ramp.sv
module fx_ramp #(
    parameter int SHORT_T = 500,
    parameter int LONG_T  = 1000,
    parameter int VAL_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             long_sel,
    input  logic [VAL_W-1:0] target,
    output logic [VAL_W-1:0] value,
    output logic             busy
);
    localparam int CW = $clog2(LONG_T + 1);

    typedef struct packed {
        logic [CW-1:0]    k;
        logic [CW-1:0]    dur;
        logic [CW:0]      acc;
        logic [VAL_W-1:0] val;
        logic [VAL_W-1:0] tgt;
        logic             busy;
    } rmp_st_t;

    rmp_st_t     st_d, st_q;
    logic [CW:0] acc_n;

    always_comb begin
        st_d  = st_q;
        acc_n = '0;
        if (start) begin
            st_d.k    = '0;
            st_d.acc  = '0;
            st_d.val  = '0;
            st_d.busy = 1'b1;
            st_d.dur  = long_sel ? CW'(LONG_T) : CW'(SHORT_T);
            st_d.tgt  = target;
        end else if (st_q.busy && tick) begin
            acc_n = st_q.acc + (CW+1)'(st_q.tgt);
            if (acc_n >= {1'b0, st_q.dur}) begin
                acc_n    = acc_n - {1'b0, st_q.dur};
                st_d.val = st_q.val + 1'b1;
            end
            st_d.acc = acc_n;
            st_d.k   = st_q.k + 1'b1;
            if (st_q.k + 1'b1 == st_q.dur) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.k    <= '0;
            st_q.dur  <= CW'(SHORT_T);
            st_q.acc  <= '0;
            st_q.val  <= '0;
            st_q.tgt  <= '0;
            st_q.busy <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;
    assign busy  = st_q.busy;
endmodule

// File: rtl/fx_timebase.sv
module fx_timebase #(
    parameter int SHORT_T = 500,
    parameter int LONG_T  = 1000,
    parameter int LINE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              blink_fast,
    input  logic [1:0]        blink_duty,
    input  logic              cblink_en,
    input  logic              scroll_en,
    input  logic              scroll_long,
    input  logic              scroll_dir,
    input  logic              scroll_start,
    input  logic [LINE_W-1:0] scroll_height,
    input  logic              fade_en,
    input  logic              fade_long,
    input  logic              fade_out_sel,
    input  logic              fade_start,
    output logic              blink_visible,
    output logic              color_swap,
    output logic [LINE_W-1:0] scroll_line,
    output logic              scroll_busy,
    output logic              scroll_erase,
    output logic [3:0]        fade_level
);
    import fx_pkg::*;

    typedef struct packed {
        logic erase;
        logic fade_out;
    } dir_st_t;

    dir_st_t           dir_d, dir_q;
    logic              scr_go, fade_go, fade_busy;
    logic [FADE_W-1:0] fade_ramp;

    assign scr_go  = scroll_start && scroll_en;
    assign fade_go = fade_start && fade_en;

    fx_blink_phase #(.SHORT_T(SHORT_T), .LONG_T(LONG_T)) u_blink (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .fast_sel(blink_fast),
        .duty(blink_duty), .swap_en(cblink_en),
        .vis(blink_visible), .swap(color_swap)
    );

    fx_ramp #(.SHORT_T(SHORT_T), .LONG_T(LONG_T), .VAL_W(LINE_W)) u_scroll (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .start(scr_go),
        .long_sel(scroll_long), .target(scroll_height),
        .value(scroll_line), .busy(scroll_busy)
    );

    fx_ramp #(.SHORT_T(SHORT_T), .LONG_T(LONG_T), .VAL_W(FADE_W)) u_fade (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .start(fade_go),
        .long_sel(fade_long), .target(FADE_W'(FADE_TOP)),
        .value(fade_ramp), .busy(fade_busy)
    );

    always_comb begin
        dir_d = dir_q;
        if (scr_go)  dir_d.erase    = scroll_dir;
        if (fade_go) dir_d.fade_out = fade_out_sel;
        if (!fade_en) begin
            fade_level = 4'(FADE_TOP);
        end else if (dir_q.fade_out) begin
            fade_level = 4'(FADE_TOP) - fade_ramp;
        end else begin
            fade_level = fade_ramp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            dir_q <= dir_d;
        end
    end

    assign scroll_erase = dir_q.erase;
endmodule

// File: rtl/fx_timebase_chk.sv
module fx_timebase_chk #(
    parameter int LINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_ms,
    input logic [1:0]        blink_duty,
    input logic              scroll_start,
    input logic              fade_en,
    input logic              blink_visible,
    input logic              color_swap,
    input logic [LINE_W-1:0] scroll_line,
    input logic              scroll_busy,
    input logic [3:0]        fade_level
);
    // R3
    duty_off_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_duty == 2'd0) |-> blink_visible);

    // R5
    swap_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        color_swap |-> !blink_visible);

    // R6
    scroll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_ms && !scroll_start) |=> $stable(scroll_line));

    // R6
    scroll_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scroll_busy && !tick_ms && !scroll_start) |=> (scroll_line == $past(scroll_line)));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scroll_busy) |-> $past(tick_ms));

    // R10
    fade_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fade_en |-> (fade_level == 4'd15));
endmodule

bind fx_timebase fx_timebase_chk #(.LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .blink_duty(blink_duty),
    .scroll_start(scroll_start), .fade_en(fade_en),
    .blink_visible(blink_visible), .color_swap(color_swap),
    .scroll_line(scroll_line), .scroll_busy(scroll_busy), .fade_level(fade_level)
);

// File: tb/fx_timebase_bench.sv
module fx_timebase_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       blink_fast = 1'b0;
    logic [1:0] blink_duty = 2'd0;
    logic       cblink_en = 1'b0;
    logic       scroll_en = 1'b0, scroll_long = 1'b0, scroll_dir = 1'b0, scroll_start = 1'b0;
    logic [7:0] scroll_height = 8'd0;
    logic       fade_en = 1'b0, fade_long = 1'b0, fade_out_sel = 1'b0, fade_start = 1'b0;
    logic       blink_visible, color_swap, scroll_busy, scroll_erase;
    logic [7:0] scroll_line;
    logic [3:0] fade_level;

    always #2 clk = ~clk;

    fx_timebase u_fx_timebase (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .blink_fast(blink_fast),
        .blink_duty(blink_duty), .cblink_en(cblink_en), .scroll_en(scroll_en),
        .scroll_long(scroll_long), .scroll_dir(scroll_dir), .scroll_start(scroll_start),
        .scroll_height(scroll_height), .fade_en(fade_en), .fade_long(fade_long),
        .fade_out_sel(fade_out_sel), .fade_start(fade_start),
        .blink_visible(blink_visible), .color_swap(color_swap), .scroll_line(scroll_line),
        .scroll_busy(scroll_busy), .scroll_erase(scroll_erase), .fade_level(fade_level)
    );

    typedef struct {
        int    vis, swp, line, busy, ers, fade;
        string phase;
    } exp_t;

    exp_t  sb_q[$];
    int    errors = 0, checks = 0;
    bit    done = 0;
    string phase = "idle";

    // independent tick-level model
    int bcnt = 0, blong = 1;
    int sk = 0, sdur = 500, sh = 0, sers = 0, sbusy = 0;
    int fk = 0, fdur = 500, fout = 0, fbusy = 0;

    task automatic cmp(input string tag, input string ph, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0d expected=%0d", tag, ph, act, exp);
        end
    endtask

    // monitor: compare each expected item away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            cmp("R3 blink_visible", it.phase, int'(blink_visible), it.vis);
            cmp("R5 color_swap",    it.phase, int'(color_swap),    it.swp);
            cmp("R6 scroll_line",   it.phase, int'(scroll_line),   it.line);
            cmp("R7 scroll_busy",   it.phase, int'(scroll_busy),   it.busy);
            cmp("R8 scroll_erase",  it.phase, int'(scroll_erase),  it.ers);
            cmp("R9 fade_level",    it.phase, int'(fade_level),    it.fade);
        end
    end

    // driver: one cycle with optional tick and starts, model update, push
    task automatic step(input bit t, input bit ss, input bit fs);
        exp_t e;
        int   per, lvl;
        @(negedge clk);
        tick_ms = t; scroll_start = ss; fade_start = fs;
        if (t) begin
            per = blong ? 1000 : 500;
            if (bcnt == per - 1) begin bcnt = 0; blong = !blink_fast; end
            else bcnt++;
        end
        if (ss && scroll_en) begin
            sk = 0; sdur = scroll_long ? 1000 : 500; sh = int'(scroll_height);
            sers = int'(scroll_dir); sbusy = 1;
        end else if (sbusy != 0 && t) begin
            sk++; if (sk == sdur) sbusy = 0;
        end
        if (fs && fade_en) begin
            fk = 0; fdur = fade_long ? 1000 : 500; fout = int'(fade_out_sel); fbusy = 1;
        end else if (fbusy != 0 && t) begin
            fk++; if (fk == fdur) fbusy = 0;
        end
        per    = blong ? 1000 : 500;
        e.vis  = (blink_duty == 2'd0 || bcnt < (per / 4) * int'(blink_duty)) ? 1 : 0;
        e.swp  = (cblink_en && e.vis == 0) ? 1 : 0;
        e.line = sk * sh / sdur;
        e.busy = sbusy;
        e.ers  = sers;
        lvl    = fk * 15 / fdur;
        e.fade = !fade_en ? 15 : (fout != 0 ? 15 - lvl : lvl);
        e.phase = phase;
        @(posedge clk);
        sb_q.push_back(e);
        @(negedge clk);
        tick_ms = 1'b0; scroll_start = 1'b0; fade_start = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 reset blink_visible", "reset", int'(blink_visible), 1);
        cmp("R1 reset color_swap",    "reset", int'(color_swap),    0);
        cmp("R1 reset scroll_line",   "reset", int'(scroll_line),   0);
        cmp("R1 reset scroll_busy",   "reset", int'(scroll_busy),   0);
        cmp("R1 reset scroll_erase",  "reset", int'(scroll_erase),  0);
        cmp("R1 reset fade_level",    "reset", int'(fade_level),    15);
        @(posedge clk); #1;

        // R2 R4: long first period, speed change deferred to the wrap
        phase = "R2 R4 quarter duty long period, speed change mid-period";
        blink_duty = 2'd1; cblink_en = 1'b1;
        ticks(1100);
        blink_fast = 1'b1;
        ticks(900);
        phase = "R2 R3 half duty short period";
        blink_duty = 2'd2;
        ticks(520);
        phase = "R3 three-quarter duty short period";
        blink_duty = 2'd3;
        ticks(500);
        phase = "R3 duty off";
        blink_duty = 2'd0;
        ticks(60);
        blink_duty = 2'd2; blink_fast = 1'b0;

        // R6: reveal, short duration
        phase = "R6 reveal 200 lines short";
        scroll_en = 1'b1; scroll_long = 1'b0; scroll_dir = 1'b0; scroll_height = 8'd200;
        step(1'b0, 1'b1, 1'b0);
        ticks(520);
        // R7: restart in the same cycle as a tick, and mid-run restart
        phase = "R7 restart on tick and mid-run";
        step(1'b1, 1'b1, 1'b0);
        ticks(120);
        scroll_height = 8'd255;
        step(1'b1, 1'b1, 1'b0);
        ticks(505);
        // R8: wipe direction, long duration
        phase = "R6 R8 wipe 37 lines long";
        scroll_long = 1'b1; scroll_dir = 1'b1; scroll_height = 8'd37;
        step(1'b0, 1'b1, 1'b0);
        ticks(1005);
        phase = "R8 start ignored while disabled";
        scroll_en = 1'b0; scroll_dir = 1'b0; scroll_height = 8'd9;
        step(1'b1, 1'b1, 1'b0);
        ticks(40);

        // R9: fade in short, then both ramps restarting on one tick
        phase = "R9 fade-in short";
        fade_en = 1'b1; fade_long = 1'b0; fade_out_sel = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        ticks(300);
        phase = "R7 R9 scroll and fade restart on the same tick";
        scroll_en = 1'b1; scroll_long = 1'b0; scroll_height = 8'd100;
        fade_long = 1'b1; fade_out_sel = 1'b1;
        step(1'b1, 1'b1, 1'b1);
        ticks(1010);
        phase = "R10 fade disabled, start ignored";
        fade_en = 1'b0; fade_out_sel = 1'b0;
        step(1'b1, 1'b0, 1'b1);
        ticks(30);
        phase = "R9 R10 re-enabled holds previous fade-out end";
        fade_en = 1'b1;
        ticks(10);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule